// File: doc/BRIEF.md
# Block Check Sequence Generator and Checker

This unit computes the block check sequence for a byte-oriented synchronous link. It serves both directions. A transmit controller feeds it outgoing characters and reads back the check value to append. A receive controller feeds it incoming characters, including the received check bytes, and reads a pass flag. Characters arrive one per accepted valid/ready beat. A per-beat marker flags synchronization characters, which never enter the check.

Two algorithms are available: a 7-bit longitudinal check with per-character parity, and CRC16. Transparent operation forces CRC16 whatever the algorithm select says. The unit also keeps the check value from before the most recent data byte. After the controller inspects a byte, it can strike that byte from the check with a single strobe, provided it does so before the next byte is accepted. Preset values come in on a port and are loaded by a synchronous clear.

Top module: `bcs_unit`

## Requirements
- R1: `modeCrc` = 0 selects the longitudinal check and `modeCrc` = 1 selects CRC16; `transparent` = 1 forces CRC16 regardless of `modeCrc`.
- R2: In longitudinal mode every accepted data character XORs its bits 6..0 into `bcsValue[6:0]`; bit 7 of the character is ignored and `bcsValue[15:7]` reads zero.
- R3: In CRC16 mode each accepted data character is folded in least significant bit first with the polynomial x^16 + x^15 + x^2 + 1. In reflected form, each bit step computes f = value[0] ^ bit, shifts the value right by one, and XORs 0xA001 in when f = 1.
- R4: A cycle with `clear` = 1 loads `presetVal` into the check value. In longitudinal mode only `presetVal[6:0]` is kept: zeros give even LRC and ones give odd LRC.
- R5: `crcOk` is 1 exactly when CRC16 is in effect and the check value is zero. This is the case after the receiver has folded in the data followed by the check value, low byte then high byte, with no inversion.
- R6: In longitudinal mode with `isRx` = 0, `parityBit` equals the bit that gives `byteIn[6:0]` plus that bit an odd number of ones.
- R7: In longitudinal mode with `isRx` = 1, `parityErr` is 1 when the full 8-bit `byteIn` holds an even number of ones.
- R8: Whenever CRC16 is in effect (including transparent), `parityBit` and `parityErr` are 0.
- R9: A character accepted with `inSync` = 1 leaves the check value unchanged.
- R10: An `exclude` strobe with `inValid` = 0 restores the check value it had before the most recent accepted data character.
- R11: `exclude` has no effect if another character (data or sync) was accepted after that data character, if it was already used, or if it arrives in the same cycle as `inValid`, which is then accepted normally.
- R12: `inReady` is 0 during a `clear` cycle, and no character is accepted then; otherwise it is 1.
- R13: With no `clear`, no `inValid` and no `exclude`, the check value holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; check value and history to zero |
| clear | input | 1 | Synchronous load of the preset |
| presetVal | input | 16 | Preset value for the check |
| modeCrc | input | 1 | Algorithm select: 0 longitudinal, 1 CRC16 |
| transparent | input | 1 | Transparent operation, forces CRC16 and disables parity |
| isRx | input | 1 | Direction of the current character: 1 receive, 0 transmit |
| inValid | input | 1 | Character present on `byteIn` |
| inReady | output | 1 | Unit accepts a character this cycle |
| byteIn | input | 8 | Character |
| inSync | input | 1 | Character is a synchronization character |
| exclude | input | 1 | Strike the most recent data character from the check |
| bcsValue | output | 16 | Current check value |
| crcOk | output | 1 | Receive check passes |
| parityBit | output | 1 | Odd parity bit for the transmit character |
| parityErr | output | 1 | Parity error on the receive character |

## Verification
The assertions assume that `presetVal`, `modeCrc` and `transparent` stay steady from a clear to the end of the block, because the history and preset checks compare values across a cycle under one algorithm. The stimulus changes these inputs only in the cycle of a clear, or while the unit is idle and the value is not being checked. The undo property also assumes that exclude strobes are raised only with `inValid` low. The bench keeps to this except in the one deliberate same-cycle case for R11. That case is framed so that the undo property's antecedent cannot hold.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int unsigned BCS_W  = 16;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned LRC_W  = 7;

  typedef struct packed {
    logic load;  // take preset
    logic step;  // fold a data character
    logic undo;  // return to pre-character value
  } bcs_ctl_t;
endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     clear,
  input  logic     inValid,
  input  logic     inSync,
  input  logic     exclude,
  output logic     inReady,
  output bcs_ctl_t ctl
);
  logic armed;
  logic accept;

  always_comb begin
    inReady  = !clear;
    accept   = inValid && inReady;
    ctl.load = clear;
    ctl.step = accept && !inSync;
    ctl.undo = exclude && armed && !inValid && !clear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (clear) begin
      armed <= 1'b0;
    end else if (accept) begin
      armed <= !inSync;
    end else if (ctl.undo) begin
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath
  import bcs_pkg::*;
#(
  parameter int unsigned W      = BCS_W,
  parameter int unsigned CW     = CHAR_W,
  parameter int unsigned LW     = LRC_W,
  parameter logic [W-1:0] POLY  = 16'hA001
)(
  input  logic          clk,
  input  logic          rstN,
  input  bcs_ctl_t      ctl,
  input  logic          useCrc,
  input  logic [CW-1:0] byteIn,
  input  logic [W-1:0]  preset,
  output logic [W-1:0]  value
);
  localparam logic [W-1:0] LRC_MASK = W'((1 << LW) - 1);

  logic [W-1:0] curVal;
  logic [W-1:0] prevVal;
  logic [W-1:0] crcNext;
  logic [W-1:0] lrcNext;
  logic [W-1:0] foldNext;
  logic [W-1:0] loadVal;

  always_comb begin
    logic [W-1:0] acc;
    logic fb;
    acc = curVal;
    for (int i = 0; i < CW; i++) begin
      fb  = acc[0] ^ byteIn[i];
      acc = acc >> 1;
      if (fb) acc = acc ^ POLY;
    end
    crcNext  = acc;
    lrcNext  = (curVal ^ W'(byteIn)) & LRC_MASK;
    foldNext = useCrc ? crcNext : lrcNext;
    loadVal  = useCrc ? preset : (preset & LRC_MASK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curVal  <= '0;
      prevVal <= '0;
    end else if (ctl.load) begin
      curVal  <= loadVal;
      prevVal <= loadVal;
    end else if (ctl.step) begin
      prevVal <= curVal;
      curVal  <= foldNext;
    end else if (ctl.undo) begin
      curVal  <= prevVal;
    end
  end

  assign value = curVal;
endmodule

// File: rtl/bcs_unit.sv
module bcs_unit
  import bcs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic [15:0] presetVal,
  input  logic        modeCrc,
  input  logic        transparent,
  input  logic        isRx,
  input  logic        inValid,
  output logic        inReady,
  input  logic [7:0]  byteIn,
  input  logic        inSync,
  input  logic        exclude,
  output logic [15:0] bcsValue,
  output logic        crcOk,
  output logic        parityBit,
  output logic        parityErr
);
  bcs_ctl_t ctl;
  logic     useCrc;
  logic     parityOn;

  assign useCrc   = modeCrc || transparent;
  assign parityOn = !useCrc;

  bcs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clear(clear), .inValid(inValid),
    .inSync(inSync), .exclude(exclude), .inReady(inReady), .ctl(ctl)
  );

  bcs_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .useCrc(useCrc),
    .byteIn(byteIn), .preset(presetVal), .value(bcsValue)
  );

  assign crcOk     = useCrc && (bcsValue == '0);
  assign parityBit = parityOn && !isRx && !(^byteIn[LRC_W-1:0]);
  assign parityErr = parityOn && isRx && !(^byteIn);
endmodule

// File: rtl/bcs_unit_chk.sv
module bcs_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        clear,
  input logic [15:0] presetVal,
  input logic        modeCrc,
  input logic        transparent,
  input logic        inValid,
  input logic        inReady,
  input logic        inSync,
  input logic        exclude,
  input logic [15:0] bcsValue,
  input logic        crcOk,
  input logic        parityBit,
  input logic        parityErr
);
  p_clear_blocks_r12: assert property (@(posedge clk) disable iff (!rstN)
    clear |-> !inReady);

  p_ok_means_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    crcOk |-> (bcsValue == 16'h0) && (modeCrc || transparent));

  p_parity_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeCrc || transparent) |-> !parityBit && !parityErr);

  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    !clear && !inValid && !exclude |=> $stable(bcsValue));

  p_sync_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !clear && inValid && inSync |=> $stable(bcsValue));

  p_preset_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    clear && (modeCrc || transparent) |=> bcsValue == $past(presetVal));

  p_lrc_narrow_r2: assert property (@(posedge clk) disable iff (!rstN)
    clear && !modeCrc && !transparent |=> bcsValue[15:7] == 9'h0);

  p_undo_restore_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && inReady && !inSync) && exclude && !inValid && !clear
    |=> bcsValue == $past(bcsValue, 2));
endmodule

bind bcs_unit bcs_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .clear(clear), .presetVal(presetVal),
  .modeCrc(modeCrc), .transparent(transparent), .inValid(inValid),
  .inReady(inReady), .inSync(inSync), .exclude(exclude),
  .bcsValue(bcsValue), .crcOk(crcOk), .parityBit(parityBit),
  .parityErr(parityErr)
);

// File: tb/bcs_unit_tb.sv
module bcs_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clear = 1'b0;
  logic [15:0] presetVal = '0;
  logic        modeCrc = 1'b0;
  logic        transparent = 1'b0;
  logic        isRx = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  byteIn = '0;
  logic        inSync = 1'b0;
  logic        exclude = 1'b0;
  logic [15:0] bcsValue;
  logic        crcOk;
  logic        parityBit;
  logic        parityErr;

  int nVec = 0;
  int nBad = 0;
  logic [15:0] model;

  always #2 clk = ~clk;

  bcs_unit u_dut (
    .clk(clk), .rstN(rstN), .clear(clear), .presetVal(presetVal),
    .modeCrc(modeCrc), .transparent(transparent), .isRx(isRx),
    .inValid(inValid), .inReady(inReady), .byteIn(byteIn),
    .inSync(inSync), .exclude(exclude), .bcsValue(bcsValue),
    .crcOk(crcOk), .parityBit(parityBit), .parityErr(parityErr)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [15:0] crcModel(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if ((r[0] ^ d[i]) == 1'b1) r = (r >> 1) ^ 16'hA001;
      else r = r >> 1;
    end
    return r;
  endfunction

  task automatic doClear(input logic [15:0] p);
    @(negedge clk);
    presetVal = p; clear = 1'b1; inValid = 1'b1; byteIn = 8'h5A;
    #0 check("R12 ready low in clear", {15'h0, inReady}, 16'h0);
    @(negedge clk);
    clear = 1'b0; inValid = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input logic s);
    @(negedge clk);
    byteIn = b; inSync = s; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; inSync = 1'b0;
  endtask

  task automatic pulseExclude();
    @(negedge clk);
    exclude = 1'b1;
    @(negedge clk);
    exclude = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    nVec++; nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    logic [15:0] saved;
    logic [7:0]  lo;
    logic [7:0]  hi;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("reset value", bcsValue, 16'h0);
    check("R12 reset ready", {15'h0, inReady}, 16'h1);
    check("R5 reset crcOk in LRC", {15'h0, crcOk}, 16'h0);

    // Parity sweep over every character, all mode combinations
    for (int m = 0; m < 3; m++) begin
      modeCrc = (m == 1); transparent = (m == 2);
      for (int v = 0; v < 256; v++) begin
        byteIn = 8'(v);
        isRx = 1'b0; #1;
        if (m == 0) check("R6 parity bit", {15'h0, parityBit},
                          {15'h0, ~(^byteIn[6:0])});
        else check("R8 parity bit off", {15'h0, parityBit}, 16'h0);
        isRx = 1'b1; #1;
        if (m == 0) check("R7 parity error", {15'h0, parityErr},
                          {15'h0, ~(^byteIn)});
        else check("R8 parity error off", {15'h0, parityErr}, 16'h0);
      end
    end
    isRx = 1'b0; modeCrc = 1'b0; transparent = 1'b0;

    // Longitudinal check, even and odd presets
    for (int p = 0; p < 2; p++) begin
      doClear(p == 0 ? 16'h0000 : 16'hFFFF);
      model = (p == 0) ? 16'h0000 : 16'h007F;
      check("R4 LRC preset", bcsValue, model);
      for (int k = 0; k < 40; k++) begin
        logic [7:0] b = 8'((k * 37 + 11) ^ (k << 3));
        sendByte(b, 1'b0);
        model = model ^ {9'h0, b[6:0]};
        check("R2 LRC fold", bcsValue, model);
      end
    end

    // CRC16 under both presets, then receive verification
    for (int p = 0; p < 2; p++) begin
      modeCrc = 1'b1;
      doClear(p == 0 ? 16'h0000 : 16'hFFFF);
      model = (p == 0) ? 16'h0000 : 16'hFFFF;
      check("R4 CRC preset", bcsValue, model);
      for (int k = 0; k < 48; k++) begin
        logic [7:0] b = 8'(k * 73 + p * 29 + 5);
        sendByte(b, 1'b0);
        model = crcModel(model, b);
        check("R3 CRC fold", bcsValue, model);
      end
      lo = model[7:0]; hi = model[15:8];
      sendByte(lo, 1'b0);
      sendByte(hi, 1'b0);
      check("R5 residue zero", bcsValue, 16'h0);
      check("R5 crcOk set", {15'h0, crcOk}, 16'h1);
    end

    // Transparent forces CRC16 with LRC selected
    modeCrc = 1'b0; transparent = 1'b1;
    doClear(16'hFFFF);
    model = 16'hFFFF;
    for (int k = 0; k < 16; k++) begin
      logic [7:0] b = 8'(200 - k * 13);
      sendByte(b, 1'b0);
      model = crcModel(model, b);
      check("R1 transparent forces CRC", bcsValue, model);
    end
    transparent = 1'b0; modeCrc = 1'b1;
    doClear(16'h0000);
    model = 16'h0;
    sendByte(8'hC3, 1'b0);
    model = crcModel(model, 8'hC3);
    check("R1 mode select CRC", bcsValue, model);

    // Sync characters do not enter the check
    saved = bcsValue;
    sendByte(8'h32, 1'b1);
    check("R9 sync ignored", bcsValue, saved);
    repeat (3) @(negedge clk);
    check("R13 idle hold", bcsValue, saved);

    // Exclude directly after a data byte
    sendByte(8'h81, 1'b0);
    check("R10 step before undo", bcsValue, crcModel(saved, 8'h81));
    pulseExclude();
    check("R10 undo restores", bcsValue, saved);
    pulseExclude();
    check("R11 second undo ignored", bcsValue, saved);

    // Exclude after an idle gap still works
    sendByte(8'h44, 1'b0);
    repeat (2) @(negedge clk);
    pulseExclude();
    check("R10 undo after gap", bcsValue, saved);

    // Exclude after a further byte only reaches back one
    sendByte(8'h10, 1'b0);
    model = crcModel(saved, 8'h10);
    sendByte(8'h20, 1'b0);
    pulseExclude();
    check("R11 one level only", bcsValue, model);

    // Exclude after a sync character is ignored
    sendByte(8'h55, 1'b0);
    model = crcModel(model, 8'h55);
    sendByte(8'h32, 1'b1);
    pulseExclude();
    check("R11 undo after sync ignored", bcsValue, model);

    // Exclude together with a valid character: the character wins
    @(negedge clk);
    byteIn = 8'h77; inValid = 1'b1; exclude = 1'b1;
    @(negedge clk);
    inValid = 1'b0; exclude = 1'b0;
    model = crcModel(model, 8'h77);
    check("R11 same-cycle exclude ignored", bcsValue, model);

    // Character presented during clear is not folded
    @(negedge clk);
    presetVal = 16'h1234; clear = 1'b1; byteIn = 8'hEE; inValid = 1'b1;
    @(negedge clk);
    clear = 1'b0; inValid = 1'b0;
    check("R12 no accept during clear", bcsValue, 16'h1234);
    pulseExclude();
    check("R12 clear drops history", bcsValue, 16'h1234);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule